// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire (I2C) bus slave in front of a 256-byte byte-addressable memory. The memory is split into 16 pages of 16 bytes. It runs on a fast system clock and oversamples the bus clock and data lines. It pulls the data line low through an open-drain enable when it acknowledges or sends a 0 bit. Three strap inputs pick its bus address, so up to eight of these blocks can share one bus.

A host writes by sending the device address, a byte address and one or more data bytes. The data bytes collect in a one-page buffer and are stored only when a STOP ends the transfer. After that commit, a programmable busy period models the time the array needs to program. During that period the block ignores its own address, so a host can poll it until it answers. A host reads by first setting the address with a write that carries no data. It then sends a repeated START and reads. Reads continue through the whole array for as long as the host acknowledges.

There are two write-protect inputs. One blocks every write. The other blocks only the lower half of the array.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset every memory byte reads as 0xFF, and `sda_oe` is 0.
- R2: The first byte after a START is the device address, sent MSB first. Its bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 picks the direction (1 = read, 0 = write). On any mismatch the slave does not acknowledge that byte and ignores the bus until the next START.
- R3: In a write transfer the slave pulls SDA low during the 9th clock of the device address, the byte address and every data byte, and at no other time. It does this even when the bytes will later be blocked by protection.
- R4: Bits 7..4 of the byte address pick the page and bits 3..0 pick the byte. After each data byte only bits 3..0 increment. If more than 16 bytes are sent, the address wraps inside the page, so later bytes overwrite earlier ones.
- R5: Written bytes reach the memory only at a STOP. A START that arrives before the STOP throws away every pending byte, and no busy period follows.
- R6: A STOP that ends a write carrying at least one data byte starts a busy period of `BUSY_CYCLES` clocks. During that period the slave does not acknowledge its address, and it answers again once the period is over.
- R7: A write with only a byte address, followed by a repeated START and a read, returns bytes starting at that address. A read started without a byte address continues from the address after the last byte transferred.
- R8: In a read the slave sends bytes MSB first. It releases SDA during every 9th clock and moves on to the next address while the host acknowledges. The address wraps from 0xFF to 0x00 across page boundaries. After the host does not acknowledge, the slave stops driving.
- R9: While `wp_all_i` is 1, no byte of the memory changes.
- R10: While `wp_low_i` is 1, a commit to addresses 0x00..0x7F changes nothing, but commits to 0x80..0xFF still take effect.
- R11: `sda_oe` changes only in the clock after a detected SCL falling edge, START or STOP. It is never 1 while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Address strap bits |
| wp_all_i | input | 1 | 1 blocks all writes |
| wp_low_i | input | 1 | 1 blocks writes to the lower half |

## Verification
The bench runs directed transfers that separate the address cases: a single byte, a page write of 20 bytes that has to wrap, an aborted write, and a read that crosses 0xFF. Each case fails in its own way if the address logic is wrong. Polling right after a commit tells a working busy period apart from a missing or endless one. Polling after an aborted write confirms that an abort starts no busy period. Seeded random writes with random start offsets, lengths and protect settings are then read back one page at a time against a bench model of the page buffer. This exposes wrong wrap points, lost valid bits and protect bounds set at the wrong address.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_DEV   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_WDATA = 3'd3,
      PH_RDATA = 3'd4
   } eeslv_phase_e;

   localparam logic [3:0] DEV_PREFIX = 4'b1010;

   localparam logic [3:0] ACK_SLOT = 4'd8;
   localparam logic [3:0] ACK_DONE = 4'd9;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/eeslv_bus_sense.sv
module eeslv_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_now, sda_now;
   logic scl_q, sda_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_now = scl_i;
         assign sda_now = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe[0] <= scl_i;
               sda_pipe[0] <= sda_i;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  scl_pipe[k] <= scl_pipe[k-1];
                  sda_pipe[k] <= sda_pipe[k-1];
               end
            end
         end
         assign scl_now = scl_pipe[SYNC_STAGES-1];
         assign sda_now = sda_pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_now;
         sda_q <= sda_now;
      end
   end

   assign sda_s     = sda_now;
   assign scl_rise  =  scl_now & ~scl_q;
   assign scl_fall  = ~scl_now &  scl_q;
   assign start_det =  scl_now &  scl_q &  sda_q & ~sda_now;
   assign stop_det  =  scl_now &  scl_q & ~sda_q &  sda_now;

endmodule

// File: rtl/eeslv_busy_timer.sv
module eeslv_busy_timer #(
   parameter int BUSY_CYCLES = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);

   localparam int CW = $clog2(BUSY_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= CW'(BUSY_CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/eeslv_store.sv
module eeslv_store #(
   parameter int MEM_BYTES  = 256,
   parameter int PAGE_BYTES = 16,
   localparam int AW = $clog2(MEM_BYTES),
   localparam int PW = $clog2(PAGE_BYTES),
   localparam int GW = AW - PW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          buf_we,
   input  logic [PW-1:0] buf_idx,
   input  logic [7:0]    buf_data,
   input  logic          buf_clear,
   input  logic          commit,
   input  logic [GW-1:0] page_sel,
   input  logic          wp_all,
   input  logic          wp_low,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          pend,
   output logic          wr_any
);

   localparam int HALF = MEM_BYTES / 2;

   logic [7:0]            mem_q [MEM_BYTES];
   logic [7:0]            buf_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;
   logic [MEM_BYTES-1:0]  row_we;

   generate
      for (genvar r = 0; r < MEM_BYTES; r++) begin : g_row
         localparam int  PG    = r / PAGE_BYTES;
         localparam int  COL   = r % PAGE_BYTES;
         localparam bit  LOWER = (r < HALF);
         assign row_we[r] = commit && (page_sel == GW'(PG)) && valid_q[COL]
                            && !wp_all && !(LOWER ? wp_low : 1'b0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < MEM_BYTES; r++) mem_q[r] <= 8'hFF;
      end else begin
         for (int r = 0; r < MEM_BYTES; r++)
            if (row_we[r]) mem_q[r] <= buf_q[r % PAGE_BYTES];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int k = 0; k < PAGE_BYTES; k++) buf_q[k] <= 8'h00;
      end else if (commit || buf_clear) begin
         valid_q <= '0;
      end else if (buf_we) begin
         buf_q[buf_idx]   <= buf_data;
         valid_q[buf_idx] <= 1'b1;
      end
   end

   assign rd_data = mem_q[rd_addr];
   assign pend    = |valid_q;
   assign wr_any  = |row_we;

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
   parameter int MEM_BYTES   = 256,
   parameter int PAGE_BYTES  = 16,
   parameter int BUSY_CYCLES = 600,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_all_i,
   input  logic       wp_low_i
);
   import eeslv_pkg::*;

   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int GW = AW - PW;

   generate
      if (!is_pow2(MEM_BYTES) || MEM_BYTES > 256) begin : g_bad_mem
         $error("MEM_BYTES must be a power of two no larger than one octet of address");
      end
      if (!is_pow2(PAGE_BYTES) || PAGE_BYTES < 2 || 2 * PAGE_BYTES > MEM_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at most half the array");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least one");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   eeslv_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   eeslv_phase_e  phase_q;
   logic [3:0]    bcnt_q;
   logic [7:0]    shreg_q;
   logic [6:0]    tx_q;
   logic [AW-1:0] addr_q;
   logic          drive_q, rw_q, mack_q;

   logic          busy, pend, commit, buf_clear, buf_we, wr_any, addr_hit;
   logic [7:0]    rd_data;

   assign addr_hit  = (shreg_q[7:4] == DEV_PREFIX) && (shreg_q[3:1] == strap_i) && !busy;
   assign commit    = stop_det && (phase_q == PH_WDATA) && pend;
   assign buf_clear = start_det || (stop_det && !commit);
   assign buf_we    = scl_fall && (phase_q == PH_WDATA) && (bcnt_q == ACK_SLOT);

   eeslv_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_we    (buf_we),
      .buf_idx   (addr_q[PW-1:0]),
      .buf_data  (shreg_q),
      .buf_clear (buf_clear),
      .commit    (commit),
      .page_sel  (addr_q[AW-1:PW]),
      .wp_all    (wp_all_i),
      .wp_low    (wp_low_i),
      .rd_addr   (addr_q),
      .rd_data   (rd_data),
      .pend      (pend),
      .wr_any    (wr_any)
   );

   eeslv_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (commit),
      .busy  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bcnt_q  <= 4'd0;
         shreg_q <= 8'h00;
         tx_q    <= 7'h00;
         addr_q  <= '0;
         drive_q <= 1'b0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
      end else if (start_det) begin
         phase_q <= PH_DEV;
         bcnt_q  <= 4'd0;
         drive_q <= 1'b0;
      end else if (stop_det) begin
         phase_q <= PH_IDLE;
         bcnt_q  <= 4'd0;
         drive_q <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            if (bcnt_q < ACK_SLOT) shreg_q <= {shreg_q[6:0], sda_s};
            else                   mack_q  <= !sda_s;
            bcnt_q <= bcnt_q + 4'd1;
         end
         if (scl_fall) begin
            case (bcnt_q)
               ACK_SLOT: begin
                  case (phase_q)
                     PH_DEV: begin
                        rw_q    <= shreg_q[0];
                        drive_q <= addr_hit;
                        if (!addr_hit) phase_q <= PH_IDLE;
                     end
                     PH_ADDR: begin
                        addr_q  <= shreg_q[AW-1:0];
                        drive_q <= 1'b1;
                     end
                     PH_WDATA: begin
                        addr_q[PW-1:0] <= addr_q[PW-1:0] + PW'(1);
                        drive_q        <= 1'b1;
                     end
                     default: drive_q <= 1'b0;
                  endcase
               end
               ACK_DONE: begin
                  bcnt_q  <= 4'd0;
                  drive_q <= 1'b0;
                  case (phase_q)
                     PH_DEV: begin
                        if (rw_q) begin
                           phase_q <= PH_RDATA;
                           tx_q    <= rd_data[6:0];
                           addr_q  <= addr_q + AW'(1);
                           drive_q <= !rd_data[7];
                        end else begin
                           phase_q <= PH_ADDR;
                        end
                     end
                     PH_ADDR: phase_q <= PH_WDATA;
                     PH_RDATA: begin
                        if (mack_q) begin
                           tx_q    <= rd_data[6:0];
                           addr_q  <= addr_q + AW'(1);
                           drive_q <= !rd_data[7];
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     default: ;
                  endcase
               end
               default: begin
                  if (phase_q == PH_RDATA && bcnt_q != 4'd0) begin
                     drive_q <= !tx_q[6];
                     tx_q    <= {tx_q[5:0], 1'b0};
                  end
               end
            endcase
         end
      end
   end

   assign sda_oe = drive_q;

endmodule

// File: rtl/eeslv_checker.sv
module eeslv_checker
   import eeslv_pkg::*;
(
   input logic         clk,
   input logic         rst_n,
   input logic         sda_oe,
   input logic         scl_fall,
   input logic         start_det,
   input logic         stop_det,
   input logic         busy,
   input logic         commit,
   input logic         wr_any,
   input logic         wp_all_i,
   input eeslv_phase_e phase,
   input logic [3:0]   bcnt
);

   AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R11

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe); // R11

   AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && phase != PH_RDATA) |-> (bcnt >= 4'd8)); // R3

   AST_READ_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RDATA && bcnt == 4'd9) |-> !sda_oe); // R8

   AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> stop_det); // R5

   AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe); // R6

   AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(commit)); // R6

   AST_WP_ALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      wp_all_i |-> !wr_any); // R9

endmodule

bind eeprom_i2c_slave eeslv_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_oe    (sda_oe),
   .scl_fall  (scl_fall),
   .start_det (start_det),
   .stop_det  (stop_det),
   .busy      (busy),
   .commit    (commit),
   .wr_any    (wr_any),
   .wp_all_i  (wp_all_i),
   .phase     (phase_q),
   .bcnt      (bcnt_q)
);

// File: tb/eeprom_i2c_slave_bench.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_bench;

   localparam int Q = 4;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp_all = 1'b0;
   logic wp_low = 1'b0;
   logic sda_oe;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #2 clk = ~clk;

   eeprom_i2c_slave u_eeprom_i2c_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .strap_i  (STRAP),
      .wp_all_i (wp_all),
      .wp_low_i (wp_low)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] ref_mem [256];
   logic [7:0] pay [32];
   logic [7:0] got [32];
   int ref_ptr = 0;

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); b = sda_line; hq(); scl_m = 1'b0; hq();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      logic x;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(x);
      ack = !x;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit master_ack);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         get_bit(x);
         v[i] = x;
      end
      put_bit(!master_ack);
   endtask

   function automatic logic [7:0] dev(input bit rd);
      return {4'b1010, STRAP, rd};
   endfunction

   function automatic void model_write(input logic [7:0] a, input int n);
      logic [7:0] pbuf [16];
      bit pv [16];
      for (int j = 0; j < 16; j++) begin pv[j] = 1'b0; pbuf[j] = 8'h00; end
      for (int i = 0; i < n; i++) begin
         int idx = (int'(a) + i) % 16;
         pbuf[idx] = pay[i];
         pv[idx] = 1'b1;
      end
      if (n > 0 && !wp_all && !(wp_low && a < 8'h80))
         for (int j = 0; j < 16; j++)
            if (pv[j]) ref_mem[(int'(a) & 8'hF0) | j] = pbuf[j];
      ref_ptr = (int'(a) & 8'hF0) | ((int'(a) + n) % 16);
   endfunction

   task automatic write_txn(input logic [7:0] a, input int n, input string req);
      bit ack;
      bus_start();
      send_byte(dev(1'b0), ack); chk({req, " dev ack"}, ack, 1);
      send_byte(a, ack);         chk({req, " addr ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(pay[i], ack); chk({req, " data ack"}, ack, 1);
      end
      bus_stop();
      model_write(a, n);
   endtask

   task automatic poll_ready(output int tries);
      tries = 0;
      for (int k = 0; k < 40; k++) begin
         bit ack;
         bus_start();
         send_byte(dev(1'b0), ack);
         bus_stop();
         tries++;
         if (ack) break;
      end
   endtask

   task automatic read_txn(input logic [7:0] a, input int n, input string req);
      bit ack;
      bus_start();
      send_byte(dev(1'b0), ack); chk({req, " dev ack"}, ack, 1);
      send_byte(a, ack);         chk({req, " addr ack"}, ack, 1);
      bus_start();
      send_byte(dev(1'b1), ack); chk({req, " read dev ack"}, ack, 1);
      for (int i = 0; i < n; i++) recv_byte(got[i], i < n - 1);
      bus_stop();
      for (int i = 0; i < n; i++) chk({req, " data"}, got[i], ref_mem[(int'(a) + i) % 256]);
      ref_ptr = (int'(a) + n) % 256;
   endtask

   task automatic cur_read(input int n, input string req);
      bit ack;
      bus_start();
      send_byte(dev(1'b1), ack); chk({req, " dev ack"}, ack, 1);
      for (int i = 0; i < n; i++) recv_byte(got[i], i < n - 1);
      bus_stop();
      for (int i = 0; i < n; i++) chk({req, " data"}, got[i], ref_mem[(ref_ptr + i) % 256]);
      ref_ptr = (ref_ptr + n) % 256;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int tries;
      bit ack;
      void'($urandom(32'd31337));
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;

      repeat (5) @(negedge clk);
      chk("R1 reset sda_oe", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: erased contents
      read_txn(8'h00, 4, "R1 low read");
      read_txn(8'hF0, 2, "R1 high read");

      // R2: wrong strap and wrong prefix are not acknowledged
      bus_start();
      send_byte({4'b1010, 3'b100, 1'b0}, ack); chk("R2 wrong strap", ack, 0);
      send_byte(8'h00, ack);                   chk("R2 ignored after miss", ack, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1011, STRAP, 1'b1}, ack);  chk("R2 wrong prefix", ack, 0);
      bus_stop();
      chk("R11 idle release", sda_oe, 0);

      // R3 / R6: byte write, then polling sees busy first
      pay[0] = 8'h5A;
      write_txn(8'h23, 1, "R3 byte write");
      poll_ready(tries);
      chk("R6 first poll nacked", int'(tries > 1), 1);
      chk("R6 eventually ready", int'(tries < 40), 1);
      read_txn(8'h23, 1, "R3 byte readback");

      // R4: 20 bytes from offset 0x3C wrap inside page 0x30
      for (int i = 0; i < 20; i++) pay[i] = 8'(8'hA0 + i);
      write_txn(8'h3C, 20, "R4 page write");
      poll_ready(tries);
      read_txn(8'h30, 16, "R4 page wrap");

      // R5: repeated START before STOP discards the pending bytes
      bus_start();
      send_byte(dev(1'b0), ack); chk("R5 dev ack", ack, 1);
      send_byte(8'h50, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      bus_start();
      bus_stop();
      poll_ready(tries);
      chk("R5 no busy after abort", tries, 1);
      read_txn(8'h50, 2, "R5 nothing stored");

      // R7: random read then current-address read
      read_txn(8'h30, 3, "R7 random read");
      cur_read(2, "R7 current read");

      // R8: sequential read across 0xFF
      pay[0] = 8'h3E; pay[1] = 8'h4F;
      write_txn(8'hFE, 2, "R8 setup");
      poll_ready(tries);
      read_txn(8'hFE, 4, "R8 wrap read");
      chk("R8 released after nack", sda_oe, 0);

      // R9: global protect
      wp_all = 1'b1;
      pay[0] = 8'h77; pay[1] = 8'h88;
      write_txn(8'h90, 2, "R9 protected write");
      poll_ready(tries);
      wp_all = 1'b0;
      read_txn(8'h90, 2, "R9 unchanged");

      // R10: lower-half protect
      wp_low = 1'b1;
      pay[0] = 8'h12;
      write_txn(8'h10, 1, "R10 low write");
      poll_ready(tries);
      pay[0] = 8'h34;
      write_txn(8'hA0, 1, "R10 high write");
      poll_ready(tries);
      wp_low = 1'b0;
      read_txn(8'h10, 1, "R10 low unchanged");
      read_txn(8'hA0, 1, "R10 high written");

      // R4 / R9 / R10: seeded random writes with page readback
      for (int it = 0; it < 8; it++) begin
         logic [7:0] a;
         int n;
         a = 8'($urandom % 256);
         n = 1 + int'($urandom % 20);
         wp_low = ($urandom % 4) == 0;
         wp_all = ($urandom % 6) == 0;
         for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
         write_txn(a, n, "R4 random write");
         poll_ready(tries);
         wp_low = 1'b0;
         wp_all = 1'b0;
         read_txn(a & 8'hF0, 16, "R10 random page check");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule